// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Decoder

This block listens to the two open-collector lines of a PS/2 pointing device and turns the serial traffic into movement reports. The two lines are first brought into the system clock domain. The falling edges of the device clock then mark the data samples. Each 11-bit character is checked for framing and parity. Three good characters are collected as status, X and Y, and the result is presented as one report: left and right button state, a signed 9-bit X delta, a signed 9-bit Y delta, and one overflow flag for each axis.

The report leaves on a valid/ready interface. A report stays on the pins until the consumer takes it. When the consumer keeps `rpt_ready_i` high, every report appears as a single-cycle strobe. The decoder cannot slow the device down. If a new report completes while the previous one is still waiting, the new report is discarded and the waiting one is kept unchanged.

The decoder recovers from line faults without help from outside. A character with a bad parity or stop bit discards the report being built, and so does a silence on the lines longer than the configured timeout. A first character that does not look like a status byte is skipped. After any of these events the decoder waits for the next status byte.

Top module: `ps2_mouse_decoder`

## Requirements
- R1: After reset, and in the first cycle after reset is released, `rpt_valid_o` is low and the decoder waits for a status character.
- R2: A character is 11 bits, sampled on falling edges of the synchronized device clock, sent in this order: a 0 start bit, 8 data bits with the least significant bit first, a parity bit that makes the count of ones across data and parity odd, and a 1 stop bit. While waiting for a start bit, falling edges with the data line high are ignored.
- R3: The first character of a report is the status byte. Its bit 0 gives `rpt_btn_left_o` and bit 1 gives `rpt_btn_right_o`. Bit 4 is the X sign, bit 5 the Y sign, bit 6 gives `rpt_ovf_x_o` and bit 7 gives `rpt_ovf_y_o`. The outputs are `rpt_dx_o = {X sign, second byte}` and `rpt_dy_o = {Y sign, third byte}`, both in two's complement.
- R4: A character received in the status position with bit 3 equal to 0 is discarded. The decoder stays in the status position.
- R5: A character with a wrong parity bit or a 0 stop bit discards the partly built report. The next good character is treated as a status byte.
- R6: If a character or a report is partly received and no device clock falling edge arrives for `TIMEOUT_CYC` system cycles, the partial data is discarded and the decoder waits for a status character.
- R7: While `rpt_valid_o` is high and `rpt_ready_i` is low, `rpt_valid_o` stays high and all report fields stay stable. A report is taken in a cycle with both high, and `rpt_valid_o` is low in the next cycle.
- R8: A report that completes while an earlier report is still waiting (valid high, ready low) is dropped. The earlier report is delivered unchanged.
- R9: `rpt_valid_o` rises exactly `SYNC_STAGES + 2` system clock cycles after the device clock line falls for the stop bit of the third character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Device clock line, asynchronous |
| ps2_dat_i | input | 1 | Device data line, asynchronous |
| rpt_valid_o | output | 1 | Report valid |
| rpt_ready_i | input | 1 | Report accepted when high together with valid |
| rpt_btn_left_o | output | 1 | Left button pressed |
| rpt_btn_right_o | output | 1 | Right button pressed |
| rpt_ovf_x_o | output | 1 | X movement overflowed |
| rpt_ovf_y_o | output | 1 | Y movement overflowed |
| rpt_dx_o | output | 9 | Signed X delta, positive to the right |
| rpt_dy_o | output | 9 | Signed Y delta, positive upward |

## Verification
The bench sweeps all 64 combinations of the six meaningful status bits, each with computed X and Y bytes, plus the extreme byte values. A design that misplaces a status field or drops the sign bit in front of a magnitude therefore fails one of these sweep reports.

Directed runs cover the recovery paths. The first is a bad parity bit in the X character. The second is a bad stop bit in the Y character. The third is a stall between two characters, and the fourth is a stall in the middle of a character. Each of these is followed by a clean report. A decoder that does not resynchronize emits a mixed report, such as an old status combined with new magnitudes. A decoder that does not check bit 3 is thrown off by one leading junk byte.

Two more runs cover the output interface. One holds ready low across two complete reports and catches a decoder that overwrites or duplicates the waiting report. The other counts the cycles from the final stop-bit edge to the strobe and catches a changed pipeline depth.

// File: rtl/ps2m_pkg.sv
`timescale 1ns/1ps
package ps2m_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned PAR_POS   = DATA_BITS + 1;
  localparam int unsigned STOP_POS  = DATA_BITS + 2;
  localparam int unsigned POS_W     = $clog2(STOP_POS + 1);

  localparam int unsigned ST_LEFT  = 0;
  localparam int unsigned ST_RIGHT = 1;
  localparam int unsigned ST_MARK  = 3;
  localparam int unsigned ST_XSIGN = 4;
  localparam int unsigned ST_YSIGN = 5;
  localparam int unsigned ST_XOVF  = 6;
  localparam int unsigned ST_YOVF  = 7;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_X      = 2'd1,
    SLOT_Y      = 2'd2
  } ps2m_slot_e;

  typedef struct packed {
    logic       btn_l;
    logic       btn_r;
    logic       ovf_x;
    logic       ovf_y;
    logic [8:0] dx;
    logic [8:0] dy;
  } ps2m_report_t;
endpackage

// File: rtl/ps2m_line_sync.sv
`timescale 1ns/1ps
module ps2m_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic fall_o,
  output logic bit_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] c_sh;
  logic [STAGES-1:0] d_sh;
  logic              c_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_sh <= '1;
          d_sh <= '1;
        end else begin
          c_sh <= clk_line_i;
          d_sh <= dat_line_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_sh <= '1;
          d_sh <= '1;
        end else begin
          c_sh <= {c_sh[STAGES-2:0], clk_line_i};
          d_sh <= {d_sh[STAGES-2:0], dat_line_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_prev <= 1'b1;
    else        c_prev <= c_sh[LAST];
  end

  assign fall_o = c_prev & ~c_sh[LAST];
  assign bit_o  = d_sh[LAST];
endmodule

// File: rtl/ps2m_word_rx.sv
`timescale 1ns/1ps
module ps2m_word_rx
  import ps2m_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic                 bit_i,
  input  logic                 flush_i,
  output logic                 byte_vld_o,
  output logic                 err_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 busy_o
);
  logic [POS_W-1:0]     pos;
  logic [DATA_BITS-1:0] sh;
  logic                 par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      sh         <= '0;
      par        <= 1'b0;
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (flush_i) begin
        pos <= '0;
      end else if (fall_i) begin
        if (pos == '0) begin
          if (!bit_i) pos <= POS_W'(1);
        end else if (pos <= POS_W'(DATA_BITS)) begin
          sh  <= {bit_i, sh[DATA_BITS-1:1]};
          pos <= pos + POS_W'(1);
        end else if (pos == POS_W'(PAR_POS)) begin
          par <= bit_i;
          pos <= pos + POS_W'(1);
        end else begin
          pos <= '0;
          if (bit_i && (^{sh, par})) byte_vld_o <= 1'b1;
          else                       err_o      <= 1'b1;
        end
      end
    end
  end

  assign byte_o = sh;
  assign busy_o = (pos != '0);
endmodule

// File: rtl/ps2m_pkt_asm.sv
`timescale 1ns/1ps
module ps2m_pkt_asm
  import ps2m_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic                 rx_busy_i,
  input  logic                 byte_vld_i,
  input  logic                 err_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 ready_i,
  output logic                 flush_o,
  output logic                 valid_o,
  output ps2m_report_t         report_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

  ps2m_slot_e     slot;
  logic [TW-1:0]  idle_cnt;
  logic           busy;
  logic           st_l, st_r, st_xs, st_ys, st_xv, st_yv;
  logic [7:0]     x_mag;
  logic           unused_bit2;

  assign unused_bit2 = byte_i[2];
  assign busy    = rx_busy_i || (slot != SLOT_STATUS);
  assign flush_o = busy && (idle_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (fall_i || !busy) idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= SLOT_STATUS;
      valid_o  <= 1'b0;
      report_o <= '0;
      {st_l, st_r, st_xs, st_ys, st_xv, st_yv} <= '0;
      x_mag    <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (flush_o || err_i) begin
        slot <= SLOT_STATUS;
      end else if (byte_vld_i) begin
        unique case (slot)
          SLOT_STATUS: begin
            if (byte_i[ST_MARK]) begin
              st_l  <= byte_i[ST_LEFT];
              st_r  <= byte_i[ST_RIGHT];
              st_xs <= byte_i[ST_XSIGN];
              st_ys <= byte_i[ST_YSIGN];
              st_xv <= byte_i[ST_XOVF];
              st_yv <= byte_i[ST_YOVF];
              slot  <= SLOT_X;
            end
          end
          SLOT_X: begin
            x_mag <= byte_i;
            slot  <= SLOT_Y;
          end
          default: begin
            slot <= SLOT_STATUS;
            if (!valid_o || ready_i) begin
              valid_o        <= 1'b1;
              report_o.btn_l <= st_l;
              report_o.btn_r <= st_r;
              report_o.ovf_x <= st_xv;
              report_o.ovf_y <= st_yv;
              report_o.dx    <= {st_xs, x_mag};
              report_o.dy    <= {st_ys, byte_i};
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_mouse_decoder.sv
`timescale 1ns/1ps
module ps2_mouse_decoder
  import ps2m_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       rpt_valid_o,
  input  logic       rpt_ready_i,
  output logic       rpt_btn_left_o,
  output logic       rpt_btn_right_o,
  output logic       rpt_ovf_x_o,
  output logic       rpt_ovf_y_o,
  output logic [8:0] rpt_dx_o,
  output logic [8:0] rpt_dy_o
);
  logic                 edge_fall;
  logic                 line_bit;
  logic                 rx_flush;
  logic                 rx_vld;
  logic                 rx_err;
  logic                 rx_busy;
  logic [DATA_BITS-1:0] rx_byte;
  ps2m_report_t         rpt;

  ps2m_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_line_i (ps2_clk_i),
    .dat_line_i (ps2_dat_i),
    .fall_o     (edge_fall),
    .bit_o      (line_bit)
  );

  ps2m_word_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (edge_fall),
    .bit_i      (line_bit),
    .flush_i    (rx_flush),
    .byte_vld_o (rx_vld),
    .err_o      (rx_err),
    .byte_o     (rx_byte),
    .busy_o     (rx_busy)
  );

  ps2m_pkt_asm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (edge_fall),
    .rx_busy_i  (rx_busy),
    .byte_vld_i (rx_vld),
    .err_i      (rx_err),
    .byte_i     (rx_byte),
    .ready_i    (rpt_ready_i),
    .flush_o    (rx_flush),
    .valid_o    (rpt_valid_o),
    .report_o   (rpt)
  );

  assign rpt_btn_left_o  = rpt.btn_l;
  assign rpt_btn_right_o = rpt.btn_r;
  assign rpt_ovf_x_o     = rpt.ovf_x;
  assign rpt_ovf_y_o     = rpt.ovf_y;
  assign rpt_dx_o        = rpt.dx;
  assign rpt_dy_o        = rpt.dy;
endmodule

// File: rtl/ps2_mouse_decoder_chk.sv
`timescale 1ns/1ps
module ps2_mouse_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       edge_fall,
  input logic       rpt_valid_o,
  input logic       rpt_ready_i,
  input logic       rpt_btn_left_o,
  input logic       rpt_btn_right_o,
  input logic       rpt_ovf_x_o,
  input logic       rpt_ovf_y_o,
  input logic [8:0] rpt_dx_o,
  input logic [8:0] rpt_dy_o
);
  logic [21:0] fields;
  assign fields = {rpt_btn_left_o, rpt_btn_right_o, rpt_ovf_x_o, rpt_ovf_y_o, rpt_dx_o, rpt_dy_o};

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rpt_valid_o);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && !rpt_ready_i) |=> (rpt_valid_o && $stable(fields)));

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && rpt_ready_i) |=> !rpt_valid_o);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid_o) |-> $past(edge_fall, 2));
endmodule

bind ps2_mouse_decoder ps2_mouse_decoder_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .edge_fall       (edge_fall),
  .rpt_valid_o     (rpt_valid_o),
  .rpt_ready_i     (rpt_ready_i),
  .rpt_btn_left_o  (rpt_btn_left_o),
  .rpt_btn_right_o (rpt_btn_right_o),
  .rpt_ovf_x_o     (rpt_ovf_x_o),
  .rpt_ovf_y_o     (rpt_ovf_y_o),
  .rpt_dx_o        (rpt_dx_o),
  .rpt_dy_o        (rpt_dy_o)
);

// File: tb/tb_ps2_mouse_decoder.sv
`timescale 1ns/1ps
module tb_ps2_mouse_decoder;
  localparam int SYNC = 2;
  localparam int TMO  = 200;
  localparam int HALF = 10;
  localparam int GAP  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ck = 1'b1;
  logic dat = 1'b1;
  logic rdy = 1'b1;
  logic       v, bl, br, ox, oy;
  logic [8:0] dx, dy;

  always #10 clk = ~clk;

  ps2_mouse_decoder #(.SYNC_STAGES(SYNC), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ck), .ps2_dat_i(dat),
    .rpt_valid_o(v), .rpt_ready_i(rdy),
    .rpt_btn_left_o(bl), .rpt_btn_right_o(br),
    .rpt_ovf_x_o(ox), .rpt_ovf_y_o(oy),
    .rpt_dx_o(dx), .rpt_dy_o(dy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cap_n = 0;
  int rd = 0;
  bit done = 1'b0;
  logic [21:0] cap [0:255];

  always @(negedge clk) begin
    if (rst_n && v && rdy && cap_n < 256) begin
      cap[cap_n] = {bl, br, ox, oy, dx, dy};
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    dat = b;
    tick(HALF);
    ck = 1'b0;
    tick(HALF);
    ck = 1'b1;
  endtask

  task automatic send_word(input logic [7:0] b, input bit bad_par, input bit bad_stop, input int nbits);
    logic [10:0] w;
    w = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int k = 0; k < nbits; k++) send_bit(w[k]);
    dat = 1'b1;
  endtask

  task automatic send_pkt(input logic [7:0] st, input logic [7:0] x, input logic [7:0] y);
    send_word(st, 0, 0, 11); tick(GAP);
    send_word(x, 0, 0, 11);  tick(GAP);
    send_word(y, 0, 0, 11);  tick(GAP);
  endtask

  function automatic logic [21:0] expect_of(input logic [7:0] st, input logic [7:0] x, input logic [7:0] y);
    return {st[0], st[1], st[6], st[7], st[4], x, st[5], y};
  endfunction

  task automatic expect_pkt(input string req, input logic [7:0] st, input logic [7:0] x, input logic [7:0] y);
    if (rd >= cap_n) begin
      check(req, 32'(cap_n), 32'(rd + 1));
    end else begin
      check(req, 32'(cap[rd]), 32'(expect_of(st, x, y)));
      rd++;
    end
  endtask

  task automatic expect_drained(input string req);
    check(req, 32'(cap_n), 32'(rd));
    rd = cap_n;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, x, y;
    tick(5);
    check("R1 valid in reset", 32'(v), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    check("R1 valid after release", 32'(v), 32'd0);
    tick(10);

    // R2 R3: sweep of the six status flags with computed magnitudes
    for (int i = 0; i < 64; i++) begin
      st = {i[5], i[4], i[3], i[2], 1'b1, 1'b0, i[1], i[0]};
      x  = 8'((i * 37 + 5) % 256);
      y  = 8'((i * 91 + 200) % 256);
      send_pkt(st, x, y);
      expect_pkt("R2 R3 sweep", st, x, y);
    end
    send_pkt(8'hFF, 8'h00, 8'hFF); expect_pkt("R3 extreme a", 8'hFF, 8'h00, 8'hFF);
    send_pkt(8'h08, 8'hFF, 8'h00); expect_pkt("R3 extreme b", 8'h08, 8'hFF, 8'h00);
    // R2: idle falls with data high before a start bit are ignored
    send_bit(1'b1); send_bit(1'b1); tick(GAP);
    send_pkt(8'h19, 8'h42, 8'h81); expect_pkt("R2 idle high bits", 8'h19, 8'h42, 8'h81);
    expect_drained("R2 R3 count");

    // R4: a leading byte with bit 3 clear is skipped
    send_word(8'h00, 0, 0, 11); tick(GAP);
    send_pkt(8'h29, 8'h10, 8'h20);
    expect_pkt("R4 reject", 8'h29, 8'h10, 8'h20);
    expect_drained("R4 count");

    // R5: parity error in X, then stop error in Y
    send_word(8'h0B, 0, 0, 11); tick(GAP);
    send_word(8'h55, 1, 0, 11); tick(GAP);
    send_pkt(8'h38, 8'h7E, 8'h03);
    expect_pkt("R5 parity", 8'h38, 8'h7E, 8'h03);
    send_word(8'h09, 0, 0, 11); tick(GAP);
    send_word(8'h11, 0, 0, 11); tick(GAP);
    send_word(8'h22, 0, 1, 11); tick(GAP);
    send_pkt(8'hCA, 8'h33, 8'hC4);
    expect_pkt("R5 stop", 8'hCA, 8'h33, 8'hC4);
    expect_drained("R5 count");

    // R6: stall between characters, then in the middle of a character
    send_word(8'h1B, 0, 0, 11); tick(GAP);
    send_word(8'h66, 0, 0, 11); tick(TMO + 60);
    send_pkt(8'h28, 8'h01, 8'hFE);
    expect_pkt("R6 between bytes", 8'h28, 8'h01, 8'hFE);
    send_word(8'h18, 0, 0, 11); tick(GAP);
    send_word(8'h77, 0, 0, 5); tick(TMO + 60);
    send_pkt(8'h0A, 8'h80, 8'h7F);
    expect_pkt("R6 mid word", 8'h0A, 8'h80, 8'h7F);
    expect_drained("R6 count");

    // R7 R8: hold under back-pressure, second report dropped
    rdy = 1'b0;
    send_pkt(8'h3B, 8'h44, 8'h99);
    tick(20);
    check("R7 held valid", 32'(v), 32'd1);
    check("R7 held fields", 32'({bl, br, ox, oy, dx, dy}), 32'(expect_of(8'h3B, 8'h44, 8'h99)));
    send_pkt(8'h08, 8'h12, 8'h34);
    check("R8 old report kept", 32'({bl, br, ox, oy, dx, dy}), 32'(expect_of(8'h3B, 8'h44, 8'h99)));
    rdy = 1'b1;
    tick(3);
    check("R7 released", 32'(v), 32'd0);
    expect_pkt("R8 delivered", 8'h3B, 8'h44, 8'h99);
    tick(GAP);
    expect_drained("R8 only one");

    // R9 and R7 strobe: count cycles from the final stop edge
    send_word(8'h09, 0, 0, 11); tick(GAP);
    send_word(8'h05, 0, 0, 11); tick(GAP);
    send_word(8'h06, 0, 0, 10);
    dat = 1'b1;
    tick(HALF);
    ck = 1'b0;
    tick(SYNC + 1);
    @(negedge clk);
    check("R9 not early", 32'(v), 32'd0);
    @(negedge clk);
    check("R9 on time", 32'(v), 32'd1);
    @(negedge clk);
    check("R7 one cycle strobe", 32'(v), 32'd0);
    tick(HALF);
    ck = 1'b1;
    tick(GAP);
    expect_pkt("R9 content", 8'h09, 8'h05, 8'h06);
    expect_drained("R9 count");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule